// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block turns a physical byte address into the chip-select row that holds it. The memory is split into eight rows laid end to end. Each row has one 8-bit boundary register that holds the cumulative top of that row in units of 8 MB. A row starts where the row before it ends, and row 0 starts at address zero. A row whose boundary repeats the previous top holds no memory. A zero boundary that follows a nonzero top stands for the 2 GB ceiling.

A write port loads the boundary registers one at a time. The lookup port takes an address and, one clock later, returns a hit flag, the row index and the mask of empty rows. A status port shows the decoded base, limit and empty state of any row without delay, so software or a neighbouring block can inspect the layout.

Top module: `rdec_row_decoder`

## Requirements
- R1: A row's byte limit equals its boundary value shifted left by 23 (8 MB units), as seen on `stat_limit` in the cycle after the write.
- R2: Row 0 has base 0, and every other row has a base equal to the decoded limit of the row below it.
- R3: A row whose limit equals the previous row's limit is reported empty (`stat_empty`, bit i of `lk_empty_mask`) and is never returned by a lookup.
- R4: A boundary value of 0 that follows a nonzero previous limit decodes to a limit of 0x8000_0000 (2 GB). A zero boundary after a zero limit stays 0.
- R5: A lookup hits the lowest-numbered nonempty row whose base is at or below the address and whose limit is above it. When ranges overlap, the lower row wins.
- R6: An address that no nonempty row covers, including any address at or above the top limit, gives `lk_hit` = 0 and `lk_row` = 0.
- R7: The lookup outputs are registered. The result for the address presented before a clock edge appears after that edge, and each cycle carries a new lookup.
- R8: Reset clears every boundary register to 0. After reset all rows are empty (`lk_empty_mask` = 8'hFF) and no lookup hits.
- R9: A boundary write becomes visible to lookups from the cycle after the write. A lookup sampled on the same edge as the write uses the old value.
- R10: While `bnd_wr_en` is low, the values on `bnd_wr_sel` and `bnd_wr_val` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_wr_en | input | 1 | Write strobe for a boundary register |
| bnd_wr_sel | input | 3 | Row whose boundary is written |
| bnd_wr_val | input | 8 | Cumulative boundary in 8 MB units |
| lk_addr | input | 32 | Byte address to decode |
| lk_hit | output | 1 | Registered: the address falls in a nonempty row |
| lk_row | output | 3 | Registered: selected row, 0 on a miss |
| lk_empty_mask | output | 8 | Registered: bit i set when row i is empty |
| stat_sel | input | 3 | Row chosen for the status readout |
| stat_base | output | 32 | Decoded base address of the chosen row |
| stat_limit | output | 32 | Decoded limit (exclusive) of the chosen row |
| stat_empty | output | 1 | The chosen row is empty |

## Verification
Four layouts are used. The first is an ascending layout with one empty row in the middle and a 2 GB top. It separates empty-row skipping from the 2 GB rule and from misses above the top. The second is a non-monotonic layout with one inverted row and overlapping ranges. It shows whether the lowest row wins and whether an inverted row is treated as non-empty but unreachable. The third applies a write and a lookup on the same edge, then repeats the lookup, to separate old values from new ones. The fourth drives write data with the strobe low, then resets in the middle of a run, to show that nothing changes without the strobe and that reset clears everything.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    localparam int ROWS       = 8;
    localparam int BND_W      = 8;
    localparam int GRAN_SHIFT = 23;
    localparam int LIM_W      = BND_W + GRAN_SHIFT + 1;
    localparam int IDX_W      = $clog2(ROWS);

    typedef logic [IDX_W-1:0] row_idx_t;
    typedef logic [BND_W-1:0] bnd_t;
    typedef logic [LIM_W-1:0] addr_t;

    localparam addr_t TOP_LIMIT = addr_t'(1) << (LIM_W - 1);

    typedef struct packed {
        addr_t base;
        addr_t limit;
        logic  empty;
    } row_span_t;

    typedef struct packed {
        logic            hit;
        row_idx_t        row;
        logic [ROWS-1:0] empty;
    } lookup_res_t;

    // Convert a cumulative boundary into a byte limit; zero after a used
    // region means the full-range ceiling.
    function automatic addr_t scale_bnd(bnd_t b, addr_t prev);
        if (b == '0 && prev != '0)
            return TOP_LIMIT;
        return addr_t'(b) << GRAN_SHIFT;
    endfunction

endpackage

// File: rtl/rdec_bnd_regs.sv
module rdec_bnd_regs
    import rdec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  row_idx_t              wr_sel,
    input  bnd_t                  wr_val,
    output logic [ROWS-1:0][BND_W-1:0] bnd_o
);

    for (genvar g = 0; g < ROWS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bnd_o[g] <= '0;
            else if (wr_en && wr_sel == row_idx_t'(g))
                bnd_o[g] <= wr_val;
        end
    end

endmodule

// File: rtl/rdec_span_chain.sv
module rdec_span_chain
    import rdec_pkg::*;
(
    input  logic [ROWS-1:0][BND_W-1:0] bnd_i,
    output row_span_t [ROWS-1:0]       span_o
);

    for (genvar g = 0; g < ROWS; g++) begin : g_span
        addr_t prev_lim;
        addr_t this_lim;

        if (g == 0) begin : g_first
            assign prev_lim = '0;
        end else begin : g_next
            assign prev_lim = span_o[g-1].limit;
        end

        assign this_lim        = scale_bnd(bnd_i[g], prev_lim);
        assign span_o[g].base  = prev_lim;
        assign span_o[g].limit = this_lim;
        assign span_o[g].empty = (this_lim == prev_lim);
    end

endmodule

// File: rtl/rdec_row_match.sv
module rdec_row_match
    import rdec_pkg::*;
(
    input  addr_t                addr_i,
    input  row_span_t [ROWS-1:0] span_i,
    output lookup_res_t          res_o
);

    logic [ROWS-1:0] fits;

    for (genvar g = 0; g < ROWS; g++) begin : g_fit
        assign fits[g] = !span_i[g].empty
                       && (addr_i >= span_i[g].base)
                       && (addr_i <  span_i[g].limit);
    end

    always_comb begin
        res_o.hit = 1'b0;
        res_o.row = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            res_o.empty[i] = span_i[i].empty;
            if (fits[i]) begin
                res_o.hit = 1'b1;
                res_o.row = row_idx_t'(i);
            end
        end
    end

endmodule

// File: rtl/rdec_row_decoder.sv
module rdec_row_decoder
    import rdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bnd_wr_en,
    input  logic [2:0]  bnd_wr_sel,
    input  logic [7:0]  bnd_wr_val,
    input  logic [31:0] lk_addr,
    output logic        lk_hit,
    output logic [2:0]  lk_row,
    output logic [7:0]  lk_empty_mask,
    input  logic [2:0]  stat_sel,
    output logic [31:0] stat_base,
    output logic [31:0] stat_limit,
    output logic        stat_empty
);

    logic [ROWS-1:0][BND_W-1:0] bnd_q;
    row_span_t [ROWS-1:0]       spans;
    lookup_res_t                res_d;
    lookup_res_t                res_q;

    logic [ROWS-1:0][LIM_W-1:0] span_base_v;
    logic [ROWS-1:0][LIM_W-1:0] span_limit_v;
    logic [ROWS-1:0]            span_empty_v;

    rdec_bnd_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bnd_wr_en),
        .wr_sel (bnd_wr_sel),
        .wr_val (bnd_wr_val),
        .bnd_o  (bnd_q)
    );

    rdec_span_chain u_chain (
        .bnd_i  (bnd_q),
        .span_o (spans)
    );

    rdec_row_match u_match (
        .addr_i (lk_addr),
        .span_i (spans),
        .res_o  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q.hit   <= 1'b0;
            res_q.row   <= '0;
            res_q.empty <= '1;
        end else begin
            res_q <= res_d;
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign span_base_v[g]  = spans[g].base;
        assign span_limit_v[g] = spans[g].limit;
        assign span_empty_v[g] = spans[g].empty;
    end

    assign lk_hit        = res_q.hit;
    assign lk_row        = res_q.row;
    assign lk_empty_mask = res_q.empty;

    assign stat_base  = spans[stat_sel].base;
    assign stat_limit = spans[stat_sel].limit;
    assign stat_empty = spans[stat_sel].empty;

endmodule

// File: rtl/rdec_row_decoder_chk.sv
module rdec_row_decoder_chk
    import rdec_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [31:0]                lk_addr,
    input logic                       lk_hit,
    input logic [2:0]                 lk_row,
    input logic [7:0]                 lk_empty_mask,
    input logic [ROWS-1:0][LIM_W-1:0] span_base,
    input logic [ROWS-1:0][LIM_W-1:0] span_limit,
    input logic [ROWS-1:0]            span_empty
);

    addr_t                      addr_d;
    logic [ROWS-1:0][LIM_W-1:0] base_d;
    logic [ROWS-1:0][LIM_W-1:0] lim_d;
    logic [ROWS-1:0]            empty_d;
    logic                       lower_fit;

    always_ff @(posedge clk) begin
        addr_d  <= lk_addr;
        base_d  <= span_base;
        lim_d   <= span_limit;
        empty_d <= span_empty;
    end

    always_comb begin
        lower_fit = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            if (row_idx_t'(i) < lk_row && !empty_d[i]
                && addr_d >= base_d[i] && addr_d < lim_d[i])
                lower_fit = 1'b1;
        end
    end

    // R3
    empty_row_never_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> !lk_empty_mask[lk_row]);

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_hit && lk_empty_mask == '1));

    // R5
    hit_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (addr_d >= base_d[lk_row] && addr_d < lim_d[lk_row]));

    // R5
    lowest_row_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> !lower_fit);

    // R6
    miss_row_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_row == '0);

    // R7
    mask_latency_chk: assert property (@(posedge clk) disable iff (rst)
        lk_empty_mask == $past(span_empty));

endmodule

bind rdec_row_decoder rdec_row_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_addr       (lk_addr),
    .lk_hit        (lk_hit),
    .lk_row        (lk_row),
    .lk_empty_mask (lk_empty_mask),
    .span_base     (span_base_v),
    .span_limit    (span_limit_v),
    .span_empty    (span_empty_v)
);

// File: tb/rdec_row_decoder_test.sv
module rdec_row_decoder_test;

    typedef struct {
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  row;
        logic [7:0]  mask;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bnd_wr_en = 1'b0;
    logic [2:0]  bnd_wr_sel = '0;
    logic [7:0]  bnd_wr_val = '0;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [2:0]  lk_row;
    logic [7:0]  lk_empty_mask;
    logic [2:0]  stat_sel = '0;
    logic [31:0] stat_base;
    logic [31:0] stat_limit;
    logic        stat_empty;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;
    logic [7:0] model [8];
    exp_t q [$];

    localparam logic [31:0] MB = 32'h0010_0000;

    rdec_row_decoder uut (
        .clk(clk), .rst(rst),
        .bnd_wr_en(bnd_wr_en), .bnd_wr_sel(bnd_wr_sel), .bnd_wr_val(bnd_wr_val),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_row(lk_row),
        .lk_empty_mask(lk_empty_mask),
        .stat_sel(stat_sel), .stat_base(stat_base),
        .stat_limit(stat_limit), .stat_empty(stat_empty)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] lim_of(int r);
        logic [31:0] prev = 0;
        logic [31:0] lim  = 0;
        for (int i = 0; i <= r; i++) begin
            if (model[i] == 0 && prev != 0) lim = 32'h8000_0000;
            else lim = {model[i], 23'd0};
            if (i < r) prev = lim;
        end
        return lim;
    endfunction

    function automatic logic [31:0] base_of(int r);
        return (r == 0) ? 32'd0 : lim_of(r - 1);
    endfunction

    function automatic exp_t expect_for(logic [31:0] a, string tag);
        exp_t e;
        e.addr = a; e.hit = 0; e.row = 0; e.mask = 0; e.tag = tag;
        for (int i = 7; i >= 0; i--) begin
            e.mask[i] = (lim_of(i) == base_of(i));
            if (!e.mask[i] && a >= base_of(i) && a < lim_of(i)) begin
                e.hit = 1; e.row = 3'(i);
            end
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Driver: one action per falling edge
    task automatic lookup(logic [31:0] a, string tag);
        @(negedge clk);
        bnd_wr_en = 0;
        lk_addr = a;
        q.push_back(expect_for(a, tag));
    endtask

    task automatic write_bnd(int r, logic [7:0] v);
        @(negedge clk);
        bnd_wr_en = 1; bnd_wr_sel = 3'(r); bnd_wr_val = v;
        model[r] = v;
    endtask

    task automatic write_and_lookup(int r, logic [7:0] v, logic [31:0] a, string tag);
        @(negedge clk);
        bnd_wr_en = 1; bnd_wr_sel = 3'(r); bnd_wr_val = v;
        lk_addr = a;
        q.push_back(expect_for(a, tag));
        model[r] = v;
    endtask

    task automatic idle();
        @(negedge clk);
        bnd_wr_en = 0;
    endtask

    task automatic check_stat(int r, string tag);
        @(negedge clk);
        bnd_wr_en = 0;
        stat_sel = 3'(r);
        #1;
        check(stat_base == base_of(r) && stat_limit == lim_of(r)
              && stat_empty == (base_of(r) == lim_of(r)), tag,
              $sformatf("row %0d base/limit/empty %h/%h/%b expected %h/%h/%b",
                        r, stat_base, stat_limit, stat_empty,
                        base_of(r), lim_of(r), base_of(r) == lim_of(r)));
    endtask

    // Monitor: compares each registered result one edge after its address
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(lk_hit == e.hit && lk_row == e.row && lk_empty_mask == e.mask,
                  e.tag,
                  $sformatf("R7 addr %h hit/row/mask %b/%0d/%h expected %b/%0d/%h",
                            e.addr, lk_hit, lk_row, lk_empty_mask,
                            e.hit, e.row, e.mask));
        end
    end

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R8: reset state
        @(negedge clk);
        check(lk_hit == 0 && lk_empty_mask == 8'hFF, "R8",
              $sformatf("hit/mask %b/%h expected 0/ff", lk_hit, lk_empty_mask));
        check_stat(0, "R8");
        lookup(32'h0000_0000, "R8 lookup after reset");

        // Ascending layout: 32MB, 64MB, empty, 128MB, 2GB top, rest empty
        write_bnd(0, 8'd4);
        write_bnd(1, 8'd8);
        write_bnd(2, 8'd8);
        write_bnd(3, 8'd16);
        write_bnd(4, 8'd0);
        idle();
        check_stat(0, "R1");
        check_stat(1, "R2");
        check_stat(2, "R3");
        check_stat(3, "R1");
        check_stat(4, "R4");
        check_stat(5, "R4");
        lookup(32'h0000_0000,         "R5 row0 bottom");
        lookup(32 * MB - 1,           "R5 row0 top byte");
        lookup(32 * MB,               "R2 row1 base");
        lookup(64 * MB,               "R3 empty row skipped");
        lookup(32'h7FFF_FFFF,         "R4 2GB row");
        lookup(32'h8000_0000,         "R6 at top");
        lookup(32'hFFFF_FFFF,         "R6 far above top");

        // Non-monotonic layout: row1 inverted, row2 overlaps row0
        write_bnd(1, 8'd2);
        write_bnd(2, 8'd6);
        for (int i = 3; i < 8; i++) write_bnd(i, 8'd6);
        idle();
        check_stat(1, "R2 inverted row");
        check_stat(3, "R3");
        lookup(20 * MB, "R5 overlap lower row wins");
        lookup(40 * MB, "R5 upper overlap");
        lookup(48 * MB, "R6 above top");
        lookup(10 * MB, "R5 low address");

        // R9: write and lookup on the same edge, then again
        write_and_lookup(0, 8'd1, 20 * MB, "R9 old value in write cycle");
        lookup(20 * MB, "R9 new value next cycle");
        lookup(12 * MB, "R9 freed span now row1");

        // R10: data with strobe low
        @(negedge clk);
        bnd_wr_en = 0; bnd_wr_sel = 3'd2; bnd_wr_val = 8'd0;
        lk_addr = 40 * MB;
        q.push_back(expect_for(40 * MB, "R10 no strobe"));
        check_stat(2, "R10");

        // R8: reset in the middle of a run
        idle(); idle();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 8; i++) model[i] = 0;
        @(negedge clk);
        check(lk_hit == 0 && lk_empty_mask == 8'hFF, "R8 mid-run reset",
              $sformatf("hit/mask %b/%h expected 0/ff", lk_hit, lk_empty_mask));
        check_stat(3, "R8");
        lookup(10 * MB, "R8 no hit after reset");
        idle(); idle();

        done = 1;
        finish_run();
    end

endmodule